// File: doc/BRIEF.md
# Budgeted Peripheral Transfer Arbiter

This block sits between a group of peripheral bridges and the shared path to main memory. Each bridge holds its traffic in a local buffer and raises a ready line when it has data to move. The arbiter answers with one block line per bridge. While the arbiter is enabled, it lets at most one bridge transfer at a time.

The bridge chosen is the eligible one whose flow has the shortest replenishment period. This is rate-monotonic order, and it preempts a lower-priority flow. Each flow draws on a sporadic-server budget counted in timebase ticks. Budget consumed during an interval returns to the flow one period after that interval's first consuming tick. A budget of 9 per 72 sits alongside 5 per 8, and harmonic period sets may reach full utilisation.

Budgets and periods are written through a small register port while the arbiter is off. Switching it on refills every budget. Switching it off releases every block line and leaves access uncontrolled.

Top module: `budget_xfer_arbiter`

## Requirements
- R1: While `ctrl_en` is low, every bit of `blk_o` is 0 (1 means blocked). This holds from reset onward.
- R2: While enabled, at most one bit of `blk_o` is 0 in any cycle.
- R3: Among eligible flows, the one with the smallest configured period is unblocked, and on equal periods the lower index wins. A higher-priority flow that becomes eligible takes over from the current one.
- R4: A flow is eligible only when its `xfer_rdy` bit is 1 and its remaining budget is nonzero. With no eligible flow, every bit of `blk_o` is 1.
- R5: From the all-blocked state, an eligible flow is unblocked at the first clock edge that samples it eligible. A change of owner takes two edges. The first edge blocks the old flow, and the second unblocks the new one.
- R6: A flow's remaining budget drops by one on each edge where `tick` is 1, the flow is unblocked and its ready bit is 1. Its block line rises on the edge after the tick that used its last unit.
- R7: The units consumed from the first consuming tick onward are returned on the tick that falls a full period of ticks after that first one. The flow then becomes eligible again.
- R8: A write with `cfg_we`=1 stores `cfg_data` as budget (`cfg_kind`=0) or period (`cfg_kind`=1) of flow `cfg_sel`, but only while `ctrl_en` is 0. Writes made while enabled are ignored. The rising edge of `ctrl_en` reloads every remaining budget to its configured value.
- R9: While enabled, each flow's remaining budget plus its pending replenishment equals its configured budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Arbitration enable; 0 releases all bridges |
| tick | input | 1 | Timebase pulse, one cycle wide |
| xfer_rdy | input | N | Per-bridge data-ready |
| blk_o | output | N | Per-bridge block line, 1 = blocked |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = budget, 1 = period |
| cfg_sel | input | IW | Flow index for the write |
| cfg_data | input | W | Value written, in ticks |

## Verification
Block lines come from registers. A ready change from idle therefore shows on `blk_o` one edge later, and a handover shows after two edges with one all-blocked cycle between them. The bench drives at the falling edge and samples at the next falling edge after the counted edges. It waits several edges in the priority table so that either path has settled. A tick is held for one cycle. Budget exhaustion is checked one edge after the consuming tick, and replenishment one edge after the tick that completes the period. The enable reload is checked two edges after `ctrl_en` rises: one edge to load and one to grant.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic {
    CFG_BUDGET = 1'b0,
    CFG_PERIOD = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/bta_flow.sv
module bta_flow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic         tick,
  input  logic         consume,
  input  logic [W-1:0] budget,
  input  logic [W-1:0] period,
  output logic         has_bud
);
  logic [W-1:0] rem, amt, tmr;
  logic         pend;
  logic         use_ok, expire;

  assign use_ok  = run && consume && (rem != '0);
  assign expire  = run && tick && pend && (tmr == W'(1));
  assign has_bud = (rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      amt  <= '0;
      tmr  <= '0;
      pend <= 1'b0;
    end else if (load) begin
      rem  <= budget;
      amt  <= '0;
      tmr  <= '0;
      pend <= 1'b0;
    end else if (run) begin
      rem <= rem + (expire ? amt : '0) - W'(use_ok);
      if (expire) begin
        amt  <= use_ok ? W'(1) : '0;
        pend <= use_ok;
        tmr  <= period;
      end else begin
        if (use_ok) amt <= amt + W'(1);
        if (use_ok && !pend) begin
          pend <= 1'b1;
          tmr  <= period;
        end else if (pend && tick) begin
          tmr <= tmr - W'(1);
        end
      end
    end
  end

  AST_BUDGET_KEPT: assert property (@(posedge clk) disable iff (rst)
    run |-> ((W+1)'(rem) + (W+1)'(amt) == (W+1)'(budget))); // R9
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (run && pend) |-> (tmr != '0 && tmr <= period)); // R7
endmodule

// File: rtl/bta_pick.sv
module bta_pick #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        elig,
  input  logic [N-1:0][W-1:0] per,
  output logic [IW-1:0]       best,
  output logic                found
);
  logic [W-1:0] best_per;

  always_comb begin
    best     = '0;
    found    = 1'b0;
    best_per = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || per[i] < best_per)) begin
        best     = IW'(i);
        best_per = per[i];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/budget_xfer_arbiter.sv
module budget_xfer_arbiter #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_en,
  input  logic          tick,
  input  logic [N-1:0]  xfer_rdy,
  output logic [N-1:0]  blk_o,
  input  logic          cfg_we,
  input  logic          cfg_kind,
  input  logic [IW-1:0] cfg_sel,
  input  logic [W-1:0]  cfg_data
);
  import bta_pkg::*;

  logic [N-1:0][W-1:0] bud_cfg, per_cfg;
  logic                en_q, load, run;
  logic [IW-1:0]       owner, best;
  logic                owner_vld, found;
  logic [N-1:0]        has_bud, elig, blk_q;

  assign load  = ctrl_en && !en_q;
  assign run   = ctrl_en && en_q;
  assign elig  = xfer_rdy & has_bud & {N{run}};
  assign blk_o = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bud_cfg <= '0;
      per_cfg <= '1;
    end else if (cfg_we && !ctrl_en) begin
      if (cfg_kind == CFG_PERIOD) per_cfg[cfg_sel] <= cfg_data;
      else                        bud_cfg[cfg_sel] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= ctrl_en;
  end

  for (genvar g = 0; g < N; g++) begin : g_flow
    logic consume;
    assign consume = run && owner_vld && (owner == IW'(g)) && xfer_rdy[g] && tick;
    bta_flow #(.W(W)) u_flow (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .run     (run),
      .tick    (tick),
      .consume (consume),
      .budget  (bud_cfg[g]),
      .period  (per_cfg[g]),
      .has_bud (has_bud[g])
    );

    AST_EMPTY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (en_q && !has_bud[g]) |=> (blk_o[g] || !en_q)); // R6
  end

  bta_pick #(.N(N), .W(W)) u_pick (
    .elig  (elig),
    .per   (per_cfg),
    .best  (best),
    .found (found)
  );

  always_ff @(posedge clk) begin
    if (rst || !ctrl_en) begin
      owner     <= '0;
      owner_vld <= 1'b0;
      blk_q     <= '0;
    end else if (owner_vld) begin
      if (!(found && best == owner)) begin
        owner_vld <= 1'b0;
        blk_q     <= '1;
      end
    end else if (found) begin
      owner     <= best;
      owner_vld <= 1'b1;
      blk_q     <= ~(N'(1) << best);
    end else begin
      blk_q <= '1;
    end
  end

  AST_ONE_OPEN: assert property (@(posedge clk) disable iff (rst)
    en_q |-> ($countones(~blk_o) <= 1)); // R2
  AST_OFF_OPEN: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (blk_o == '0)); // R1
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q) && ((~blk_o & $past(blk_o)) != '0)) |-> ($past(blk_o) == '1)); // R5
endmodule

// File: tb/budget_xfer_arbiter_bench.sv
module budget_xfer_arbiter_bench;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctrl_en = 1'b0;
  logic          tick = 1'b0;
  logic [N-1:0]  xfer_rdy = '0;
  logic [N-1:0]  blk_o;
  logic          cfg_we = 1'b0;
  logic          cfg_kind = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [W-1:0]  cfg_data = '0;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  budget_xfer_arbiter #(.N(N), .W(W)) u_budget_xfer_arbiter (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .tick(tick),
    .xfer_rdy(xfer_rdy), .blk_o(blk_o), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_sel(cfg_sel), .cfg_data(cfg_data)
  );

  // ready pattern [7:4], expected block lines [3:0]
  // periods: flow0 72, flow1 8, flow2 8, flow3 40
  localparam logic [7:0] TBL [8] = '{
    8'b0001_1110, 8'b0011_1101, 8'b0111_1101, 8'b0101_1011,
    8'b1001_0111, 8'b0000_1111, 8'b1111_1101, 8'b1100_1011
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] exp);
    tests++;
    if (blk_o !== exp) begin
      fails++;
      $display("FAIL %s: blk_o got %b expected %b", tag, blk_o, exp);
    end
  endtask

  task automatic wr(input int sel, input logic kind, input int val);
    cfg_we = 1'b1; cfg_sel = IW'(sel); cfg_kind = kind; cfg_data = W'(val);
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse();
    tick = 1'b1; cyc(1);
    tick = 1'b0; cyc(1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset state", 4'b0000);

    wr(0, 1'b0, 9);  wr(0, 1'b1, 72);
    wr(1, 1'b0, 5);  wr(1, 1'b1, 8);
    wr(2, 1'b0, 5);  wr(2, 1'b1, 8);
    wr(3, 1'b0, 3);  wr(3, 1'b1, 40);

    xfer_rdy = 4'b1111; cyc(2);
    chk("R1 disabled with ready", 4'b0000);
    xfer_rdy = '0;
    ctrl_en = 1'b1; cyc(3);
    chk("R4 enabled idle", 4'b1111);

    for (int k = 0; k < 8; k++) begin
      xfer_rdy = TBL[k][7:4];
      cyc(4);
      chk($sformatf("R3 priority entry %0d", k), TBL[k][3:0]);
    end

    xfer_rdy = '0; cyc(3);
    xfer_rdy = 4'b0001; cyc(1);
    chk("R5 grant from idle", 4'b1110);
    xfer_rdy = 4'b0011; cyc(1);
    chk("R5 old owner blocked first", 4'b1111);
    cyc(1);
    chk("R5 new owner unblocked", 4'b1101);

    xfer_rdy = 4'b0100; cyc(3);
    chk("R3 flow2 granted", 4'b1011);
    for (int k = 0; k < 4; k++) pulse();
    chk("R6 budget left after 4 ticks", 4'b1011);
    pulse();
    chk("R6 blocked when budget spent", 4'b1111);
    for (int k = 0; k < 3; k++) pulse();
    chk("R7 no early replenishment", 4'b1111);
    pulse();
    chk("R7 R9 budget restored after period", 4'b1011);

    xfer_rdy = 4'b1000; cyc(3);
    chk("R3 flow3 granted", 4'b0111);
    for (int k = 0; k < 3; k++) pulse();
    chk("R6 flow3 exhausted", 4'b1111);
    ctrl_en = 1'b0; cyc(1);
    chk("R1 released on disable", 4'b0000);
    ctrl_en = 1'b1; cyc(3);
    chk("R8 budget reloaded on enable", 4'b0111);

    wr(3, 1'b0, 0);
    ctrl_en = 1'b0; cyc(1);
    ctrl_en = 1'b1; cyc(3);
    chk("R8 write while enabled ignored", 4'b0111);
    ctrl_en = 1'b0; cyc(1);
    wr(3, 1'b0, 0);
    ctrl_en = 1'b1; cyc(3);
    chk("R4 zero budget never granted", 4'b1111);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule